// File: doc/BRIEF.md
# Valley-Switching Turn-On Selector

This block decides when the power switch of a quasi-resonant flyback converter turns back on. After each switch turn-off the transformer demagnetises and the drain voltage rings; each ring produces a zero-crossing pulse. The block counts those pulses and requests turn-on at the valley whose index equals a stored target. Turn-off is decided elsewhere from feedback and current sensing. This block only produces the turn-on instant.

The valley target adapts to load. Three comparator outputs report whether the feedback voltage is above a low-zone, a high-zone and a reset threshold, in ascending order. Across each regulation window, which by default is 48 ms of a 50 MHz clock, each comparator output is held in a sticky flag. At the end of the window the flags pick one of four moves. The target then steps up, holds, steps down, or drops straight to its minimum. Light load therefore skips to later valleys, which lowers the switching frequency. Heavy load returns to the first valley.

Top module: `vsel_turn_on`

## Requirements
- R1: While reset is active and in the first cycle after it, `ton_req` is 0 and `valley_target` is 1.
- R2: A regulation window lasts `PERIOD_CYCLES` clock cycles. The first window ends on the `PERIOD_CYCLES`-th rising edge after reset release. `valley_target` changes only in the cycle that follows the end of a window.
- R3: If none of the three comparators was high during a window, the target rises by one at the window end, saturating at 7.
- R4: If `fb_gt_low` was high at least once but `fb_gt_high` and `fb_gt_reset` never were, the target is unchanged.
- R5: If `fb_gt_high` was high at least once but `fb_gt_reset` never was, the target falls by one, saturating at 1.
- R6: If `fb_gt_reset` was high at least once during a window, the target becomes 1 at the window end, whatever the other flags show.
- R7: A comparator that is high in the last cycle of a window counts toward the following window, not the one ending.
- R8: After a `gate_off` pulse, `ton_req` is high for exactly one cycle. It rises in the cycle after the edge that samples the Nth accepted `zc_pulse`, where N is the target held when `gate_off` was sampled.
- R9: A `zc_pulse` is ignored in three cases: before the first `gate_off` after reset, after a turn-on request until the next `gate_off`, and in the same cycle as a `gate_off`.
- R10: A target change made while valleys are being counted does not alter the valley count for the current switching cycle.
- R11: A `gate_off` that arrives while counting restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_gt_low | input | 1 | Feedback above the low-zone threshold |
| fb_gt_high | input | 1 | Feedback above the high-zone threshold |
| fb_gt_reset | input | 1 | Feedback above the reset threshold |
| zc_pulse | input | 1 | One-cycle pulse per drain-voltage zero crossing |
| gate_off | input | 1 | One-cycle pulse when the switch is turned off |
| ton_req | output | 1 | One-cycle turn-on request |
| valley_target | output | VAL_W | Valley index currently selected (1 to 7 by default) |

## Verification
A corrupt sticky flag or target register shows up on `valley_target` one cycle after the next window end, so any such error appears within one regulation period. A wrong captured target, valley count or arming state shows up on `ton_req` within one switching cycle. The turn-on pulse comes at the wrong valley, comes twice, or does not come at all. The bench therefore compares both outputs against its own model on every clock. It places the stimulus so that each flag combination and each ignored-pulse case is followed by an observation that would differ if the case were mishandled.

// File: rtl/vsel_pkg.sv
package vsel_pkg;

  // Sticky comparator flags for one regulation window, highest threshold first.
  typedef struct packed {
    logic rs;
    logic hi;
    logic lo;
  } fb_flags_t;

  localparam int unsigned FLAG_N = 3;

  // Target update rule applied at the end of each window.
  function automatic int unsigned step_target(input int unsigned cur,
                                              input fb_flags_t f,
                                              input int unsigned lo_lim,
                                              input int unsigned hi_lim);
    if (f.rs) return lo_lim;
    if (f.hi) return (cur > lo_lim) ? cur - 1 : lo_lim;
    if (f.lo) return cur;
    return (cur < hi_lim) ? cur + 1 : hi_lim;
  endfunction

  // True when the valley just seen is the one requested.
  function automatic logic valley_reached(input int unsigned seen,
                                          input int unsigned goal);
    return seen == goal;
  endfunction

endpackage

// File: rtl/vsel_prescaler.sv
module vsel_prescaler #(
  parameter int unsigned PERIOD_CYCLES = 2400000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (PERIOD_CYCLES > 2) ? $clog2(PERIOD_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/vsel_target_ctrl.sv
module vsel_target_ctrl
  import vsel_pkg::*;
#(
  parameter int unsigned VAL_W   = 3,
  parameter int unsigned VAL_MIN = 1,
  parameter int unsigned VAL_MAX = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cmp_lo,
  input  logic             cmp_hi,
  input  logic             cmp_rs,
  output logic [VAL_W-1:0] target,
  output fb_flags_t        flags_q
);
  logic [FLAG_N-1:0] cmp_now;
  logic [FLAG_N-1:0] sticky_q;
  logic [VAL_W-1:0]  target_nxt;

  assign cmp_now = {cmp_rs, cmp_hi, cmp_lo};
  assign flags_q = fb_flags_t'(sticky_q);

  // On the window's last cycle the live comparator value seeds the next window.
  for (genvar g = 0; g < FLAG_N; g++) begin : g_sticky
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sticky_q[g] <= 1'b0;
      else if (tick) sticky_q[g] <= cmp_now[g];
      else           sticky_q[g] <= sticky_q[g] | cmp_now[g];
    end
  end

  assign target_nxt = VAL_W'(step_target(32'(target), flags_q, VAL_MIN, VAL_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    target <= VAL_W'(VAL_MIN);
    else if (tick) target <= target_nxt;
  end
endmodule

// File: rtl/vsel_valley_cnt.sv
module vsel_valley_cnt
  import vsel_pkg::*;
#(
  parameter int unsigned VAL_W   = 3,
  parameter int unsigned VAL_MIN = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_off,
  input  logic             zc_pulse,
  input  logic [VAL_W-1:0] target,
  output logic             ton_req,
  output logic             armed,
  output logic [VAL_W-1:0] zc_count,
  output logic [VAL_W-1:0] cap_target,
  output logic             zc_accept,
  output logic             valley_hit
);
  logic [VAL_W-1:0] cnt_inc;

  // gate_off has priority: a coincident zero crossing is discarded.
  assign zc_accept  = zc_pulse & armed & ~gate_off;
  assign cnt_inc    = zc_count + VAL_W'(1);
  assign valley_hit = zc_accept & valley_reached(32'(cnt_inc), 32'(cap_target));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      zc_count   <= '0;
      cap_target <= VAL_W'(VAL_MIN);
      ton_req    <= 1'b0;
    end else begin
      ton_req <= valley_hit;
      if (gate_off) begin
        armed      <= 1'b1;
        zc_count   <= '0;
        cap_target <= target;
      end else if (zc_accept) begin
        zc_count <= cnt_inc;
        if (valley_hit) armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vsel_turn_on.sv
module vsel_turn_on
  import vsel_pkg::*;
#(
  parameter int unsigned PERIOD_CYCLES = 2400000,
  parameter int unsigned VAL_W         = 3,
  parameter int unsigned VAL_MIN       = 1,
  parameter int unsigned VAL_MAX       = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fb_gt_low,
  input  logic             fb_gt_high,
  input  logic             fb_gt_reset,
  input  logic             zc_pulse,
  input  logic             gate_off,
  output logic             ton_req,
  output logic [VAL_W-1:0] valley_target
);
  // Internal events named for the bound checker.
  logic             period_tick;
  fb_flags_t        flags_q;
  logic             armed;
  logic [VAL_W-1:0] zc_count;
  logic [VAL_W-1:0] cap_target;
  logic             zc_accept;
  logic             valley_hit;

  vsel_prescaler #(.PERIOD_CYCLES(PERIOD_CYCLES)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (period_tick)
  );

  vsel_target_ctrl #(.VAL_W(VAL_W), .VAL_MIN(VAL_MIN), .VAL_MAX(VAL_MAX)) u_tgt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (period_tick),
    .cmp_lo (fb_gt_low),
    .cmp_hi (fb_gt_high),
    .cmp_rs (fb_gt_reset),
    .target (valley_target),
    .flags_q(flags_q)
  );

  vsel_valley_cnt #(.VAL_W(VAL_W), .VAL_MIN(VAL_MIN)) u_vly (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_off  (gate_off),
    .zc_pulse  (zc_pulse),
    .target    (valley_target),
    .ton_req   (ton_req),
    .armed     (armed),
    .zc_count  (zc_count),
    .cap_target(cap_target),
    .zc_accept (zc_accept),
    .valley_hit(valley_hit)
  );
endmodule

// File: rtl/vsel_turn_on_checker.sv
module vsel_turn_on_checker
  import vsel_pkg::*;
#(
  parameter int unsigned VAL_W   = 3,
  parameter int unsigned VAL_MIN = 1,
  parameter int unsigned VAL_MAX = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate_off,
  input logic             zc_pulse,
  input logic             ton_req,
  input logic [VAL_W-1:0] valley_target,
  input logic             period_tick,
  input fb_flags_t        flags_q,
  input logic             armed,
  input logic [VAL_W-1:0] zc_count,
  input logic [VAL_W-1:0] cap_target
);
  assert_target_bounds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(valley_target) >= VAL_MIN) && (32'(valley_target) <= VAL_MAX));

  assert_target_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(valley_target) |-> $past(period_tick));

  assert_reset_flag_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (period_tick && flags_q.rs) |=> (32'(valley_target) == VAL_MIN));

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ton_req |=> !ton_req);

  assert_gate_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gate_off |=> !ton_req);

  assert_ton_needs_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ton_req |-> ($past(armed) && $past(zc_pulse) && !$past(gate_off)));

  assert_captured_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ton_req |-> (32'($past(zc_count)) + 1 == 32'($past(cap_target))));
endmodule

bind vsel_turn_on vsel_turn_on_checker #(
  .VAL_W(VAL_W), .VAL_MIN(VAL_MIN), .VAL_MAX(VAL_MAX)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .gate_off     (gate_off),
  .zc_pulse     (zc_pulse),
  .ton_req      (ton_req),
  .valley_target(valley_target),
  .period_tick  (period_tick),
  .flags_q      (flags_q),
  .armed        (armed),
  .zc_count     (zc_count),
  .cap_target   (cap_target)
);

// File: tb/vsel_turn_on_test.sv
module vsel_turn_on_test;
  localparam int PERIOD = 40;
  localparam int TMIN = 1;
  localparam int TMAX = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fb_lo = 1'b0, fb_hi = 1'b0, fb_rs = 1'b0;
  logic zc = 1'b0, goff = 1'b0;
  logic ton_req;
  logic [2:0] valley_target;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vsel_turn_on #(.PERIOD_CYCLES(PERIOD)) uut (
    .clk(clk), .rst_n(rst_n),
    .fb_gt_low(fb_lo), .fb_gt_high(fb_hi), .fb_gt_reset(fb_rs),
    .zc_pulse(zc), .gate_off(goff),
    .ton_req(ton_req), .valley_target(valley_target)
  );

  // Behavioural reference model
  int m_phase = 0, m_tgt = TMIN, m_seen = 0, m_goal = TMIN;
  bit m_lo = 0, m_hi = 0, m_rs = 0, m_wait = 0, m_ton = 0, m_tick = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_tgt = TMIN; m_seen = 0; m_goal = TMIN;
      m_lo = 0; m_hi = 0; m_rs = 0; m_wait = 0; m_ton = 0; m_tick = 0;
    end else begin
      m_ton = 0;
      if (goff) begin
        m_wait = 1; m_seen = 0; m_goal = m_tgt;
      end else if (zc && m_wait) begin
        m_seen++;
        if (m_seen == m_goal) begin m_ton = 1; m_wait = 0; end
      end
      m_tick = (m_phase == PERIOD - 1);
      if (m_tick) begin
        if (m_rs)       m_tgt = TMIN;
        else if (m_hi)  m_tgt = (m_tgt > TMIN) ? m_tgt - 1 : TMIN;
        else if (!m_lo) m_tgt = (m_tgt < TMAX) ? m_tgt + 1 : TMAX;
        m_lo = fb_lo; m_hi = fb_hi; m_rs = fb_rs;
        m_phase = 0;
      end else begin
        m_lo |= fb_lo; m_hi |= fb_hi; m_rs |= fb_rs;
        m_phase++;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8 ton_req vs model", int'(ton_req), int'(m_ton));
      chk("R2 valley_target vs model", int'(valley_target), m_tgt);
    end
  end

  // One comparator pulse early in the window, then wait for its end.
  task automatic window(input bit lo, input bit hi, input bit rs,
                        input int exp, input string tag);
    @(negedge clk); fb_lo = lo; fb_hi = hi; fb_rs = rs;
    @(negedge clk); fb_lo = 0; fb_hi = 0; fb_rs = 0;
    do @(negedge clk); while (!m_tick);
    chk(tag, int'(valley_target), exp);
  endtask

  task automatic pulse_zc(input bit exp, input string tag);
    @(negedge clk); zc = 1'b1;
    @(negedge clk); zc = 1'b0;
    chk(tag, int'(ton_req), int'(exp));
    @(negedge clk);
  endtask

  task automatic pulse_goff();
    @(negedge clk); goff = 1'b1;
    @(negedge clk); goff = 1'b0;
    chk("R9 no request after gate_off", int'(ton_req), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ton_req", int'(ton_req), 0);
    chk("R1 reset target", int'(valley_target), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first cycle target", int'(valley_target), 1);

    pulse_zc(1'b0, "R9 zc before any gate_off");

    // R3: climb to the ceiling
    for (int i = 2; i <= 7; i++) window(0, 0, 0, i, "R3 step up");
    window(0, 0, 0, 7, "R3 saturate at 7");
    window(1, 0, 0, 7, "R4 hold");
    window(0, 1, 0, 6, "R5 step down");
    window(0, 1, 0, 5, "R5 step down again");
    window(1, 1, 1, 1, "R6 force minimum");
    window(0, 1, 0, 1, "R5 saturate at 1");
    window(0, 0, 0, 2, "R3 step up");
    window(0, 0, 0, 3, "R3 step up");

    // R8: third valley
    window(1, 0, 0, 3, "R4 hold before valley test");
    pulse_goff();
    pulse_zc(1'b0, "R8 valley 1");
    pulse_zc(1'b0, "R8 valley 2");
    pulse_zc(1'b1, "R8 valley 3 fires");
    pulse_zc(1'b0, "R9 zc after request ignored");

    // R11: restart mid-count
    window(1, 0, 0, 3, "R4 hold");
    pulse_goff();
    pulse_zc(1'b0, "R11 first valley");
    pulse_goff();
    pulse_zc(1'b0, "R11 recount 1");
    pulse_zc(1'b0, "R11 recount 2");
    pulse_zc(1'b1, "R11 recount 3 fires");

    // R9: zc together with gate_off is dropped
    window(1, 0, 0, 3, "R4 hold");
    @(negedge clk); goff = 1'b1; zc = 1'b1;
    @(negedge clk); goff = 1'b0; zc = 1'b0;
    chk("R9 coincident zc", int'(ton_req), 0);
    pulse_zc(1'b0, "R9 coincident not counted 1");
    pulse_zc(1'b0, "R9 coincident not counted 2");
    pulse_zc(1'b1, "R9 coincident not counted 3");

    // R10: target drops mid-cycle, count stays on captured value
    window(1, 0, 0, 3, "R4 hold");
    pulse_goff();
    window(0, 1, 0, 2, "R10 target changed mid-cycle");
    pulse_zc(1'b0, "R10 valley 1");
    pulse_zc(1'b0, "R10 valley 2");
    pulse_zc(1'b1, "R10 fires on captured 3");

    // R7: reset flag on the window's last cycle counts for the next window
    do @(negedge clk); while (m_phase != PERIOD - 1);
    fb_rs = 1'b1;
    @(negedge clk); fb_rs = 1'b0;
    chk("R7 last-cycle flag not in ending window", int'(valley_target), 3);
    window(0, 0, 0, 1, "R7 last-cycle flag in next window");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1'b1;
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule